// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined arithmetic slice for filter and accumulator datapaths. Three signed 18-bit operands (A, B, D) feed an optional pre-adder and an 18x18 signed multiplier. A 48-bit post-adder/subtracter then combines two selected operands, X and Z, with a one-bit carry-in. The 48-bit result leaves on `result` and also on a cascade output that feeds the next slice in a chain. The carry out of the post-adder is registered together with the result.

An 8-bit control word `ctl` picks the operands and the arithmetic directions, and it is registered like the data. Each pipeline register can be removed by a parameter. Each register group has its own active-high clock enable and active-high reset, and a parameter chooses a synchronous or an asynchronous reset. When every stage is present, the slice is a four-cycle pipeline from `op_a`/`op_b` to `result`. To accumulate, the slice selects its own result as the Z operand. The result register must then stay enabled by parameter, because with that register bypassed the feedback path would be combinational.

Top module: `preadd_mac_slice`

## Requirements
- R1: Holding a register group's reset high clears that group at the next rising edge. After reset, `result`, `cy_out` and `casc_b_out` read 0.
- R2: With every stage present, a change on `op_a` or `op_b` reaches `result` on the 4th rising edge after it is applied, and not earlier.
- R3: `ctl[1:0]` selects the X operand: 0 gives zero, 1 gives the product, 2 gives the result feedback, and 3 gives the concatenation {D[11:0], A, B} with B in bits 17:0.
- R4: `ctl[3:2]` selects the Z operand: 0 gives zero, 1 gives `casc_p_in`, 2 gives the result feedback, and 3 gives the registered C operand.
- R5: When `ctl[4]` is 1, the multiplier's second operand is the pre-adder output. The pre-adder computes D+B when `ctl[6]` is 0 and D−B when it is 1, wrapping at 18 bits. When `ctl[4]` is 0, the multiplier takes B directly.
- R6: When `ctl[7]` is 0 the post-adder computes Z+(X+CIN). When it is 1, it computes Z−(X+CIN) modulo 2^48.
- R7: With `CY_FROM_CTL`=0 (the default), CIN is the registered `cy_in` and `ctl[5]` has no effect on the result. With `CY_FROM_CTL`=1, CIN is `ctl[5]`.
- R8: While a group's enable is low and its reset is low, that group's registers hold their value. For example, `result` stays constant while `en_r` is low.
- R9: `casc_b_out` carries the B value that enters the multiplier, taken after the second B stage. With the pre-adder selected, this is D±B.
- R10: `cy_out` is bit 48 of the 49-bit post-adder sum or difference, registered with `result`. This is 1 on an addition carry or a subtraction borrow. `casc_p_out` always equals `result`.
- R11: The 36-bit signed product is sign-extended to 48 bits before it enters X.
- R12: With Z set to the feedback and X set to the product, `result` grows by the product on every enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| op_a | input | 18 | Signed A operand |
| op_b | input | 18 | Signed B operand from the fabric |
| casc_b_in | input | 18 | B operand from the neighbouring slice |
| op_d | input | 18 | Signed D operand for the pre-adder |
| op_c | input | 48 | C operand for the Z multiplexer |
| casc_p_in | input | 48 | Result cascade from the neighbouring slice |
| cy_in | input | 1 | External carry-in |
| ctl | input | 8 | Control word selecting operands and directions |
| en_a | input | 1 | Clock enable, A stages |
| en_b | input | 1 | Clock enable, B stages |
| en_c | input | 1 | Clock enable, C register |
| en_d | input | 1 | Clock enable, D register |
| en_m | input | 1 | Clock enable, product register |
| en_r | input | 1 | Clock enable, result register |
| en_cy | input | 1 | Clock enable, carry-in register |
| en_ctl | input | 1 | Clock enable, control register |
| rst_a | input | 1 | Reset, A stages |
| rst_b | input | 1 | Reset, B stages |
| rst_c | input | 1 | Reset, C register |
| rst_d | input | 1 | Reset, D register |
| rst_m | input | 1 | Reset, product register |
| rst_r | input | 1 | Reset, result register and carry out |
| rst_cy | input | 1 | Reset, carry-in register |
| rst_ctl | input | 1 | Reset, control register |
| result | output | 48 | Post-adder result |
| casc_p_out | output | 48 | Result cascade to the next slice |
| casc_b_out | output | 18 | Selected B value to the next slice |
| cy_out | output | 1 | Carry or borrow out of the post-adder |

## Verification
The A and B operands reach `result` after four rising edges. The first two are the operand stages, the third is the product register and the fourth is the result register. The control word, C, D and carry-in each pass through one register and arrive well inside that window. For each table vector the bench holds its inputs for five edges and samples on the following falling edge, so every path has settled before the check. The latency test samples once after the third edge, when the old value must still be present, and again after the fourth. `casc_b_out` is checked two or more edges after a B change. The accumulation test counts single edges after the result reset is released.

// File: rtl/preadd_mac_pkg.sv
package preadd_mac_pkg;
  localparam int OPW  = 18;
  localparam int MULW = 2 * OPW;
  localparam int ACCW = 48;
  localparam int DCAT = ACCW - 2 * OPW;
  localparam int CTLW = 8;

  function automatic logic [OPW-1:0] f_pre(input logic [OPW-1:0] d, input logic [OPW-1:0] b,
                                           input logic sub);
    return sub ? (d - b) : (d + b);
  endfunction

  function automatic logic [MULW-1:0] f_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic signed [MULW-1:0] pa, pb;
    pa = MULW'($signed(a));
    pb = MULW'($signed(b));
    return MULW'(pa * pb);
  endfunction

  function automatic logic [ACCW-1:0] f_sext(input logic [MULW-1:0] m);
    return {{(ACCW-MULW){m[MULW-1]}}, m};
  endfunction

  function automatic logic [ACCW-1:0] f_xsel(input logic [1:0] sel, input logic [ACCW-1:0] prod,
                                             input logic [ACCW-1:0] fb, input logic [ACCW-1:0] cat);
    case (sel)
      2'd1:    return prod;
      2'd2:    return fb;
      2'd3:    return cat;
      default: return '0;
    endcase
  endfunction

  function automatic logic [ACCW-1:0] f_zsel(input logic [1:0] sel, input logic [ACCW-1:0] casc,
                                             input logic [ACCW-1:0] fb, input logic [ACCW-1:0] c);
    case (sel)
      2'd1:    return casc;
      2'd2:    return fb;
      2'd3:    return c;
      default: return '0;
    endcase
  endfunction

  function automatic logic [ACCW:0] f_post(input logic [ACCW-1:0] z, input logic [ACCW-1:0] x,
                                           input logic cin, input logic sub);
    logic [ACCW:0] xe;
    xe = {1'b0, x} + {{ACCW{1'b0}}, cin};
    return sub ? ({1'b0, z} - xe) : ({1'b0, z} + xe);
  endfunction
endpackage

// File: rtl/mac_opt_reg.sv
module mac_opt_reg #(
  parameter int W     = 8,
  parameter bit USE   = 1'b1,
  parameter bit ASYNC = 1'b0
) (
  input  logic         clk,
  input  logic         en,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (!USE) begin : g_bypass
      assign q = d;
    end else if (ASYNC) begin : g_async
      always_ff @(posedge clk or posedge rst)
        if (rst)     q <= '0;
        else if (en) q <= d;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (rst)     q <= '0;
        else if (en) q <= d;
    end
  endgenerate
endmodule

// File: rtl/mac_front.sv
module mac_front
  import preadd_mac_pkg::*;
#(
  parameter bit A_PIPE0 = 1'b1,
  parameter bit A_PIPE1 = 1'b1,
  parameter bit B_PIPE0 = 1'b1,
  parameter bit B_PIPE1 = 1'b1,
  parameter bit D_PIPE  = 1'b1,
  parameter bit M_PIPE  = 1'b1,
  parameter bit ASYNC_RST   = 1'b0,
  parameter bit B_FROM_CASC = 1'b0
) (
  input  logic            clk,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic [OPW-1:0]  casc_b_in,
  input  logic [OPW-1:0]  op_d,
  input  logic            pre_en,
  input  logic            pre_sub,
  input  logic            en_a, en_b, en_d, en_m,
  input  logic            rst_a, rst_b, rst_d, rst_m,
  output logic [ACCW-1:0] prod_ext,
  output logic [ACCW-1:0] cat,
  output logic [OPW-1:0]  b_mul
);
  logic [OPW-1:0]  b_src, a0, a1, b0, d0, pre_out, b_sel;
  logic [MULW-1:0] mul_raw, mul_q;

  assign b_src = B_FROM_CASC ? casc_b_in : op_b;

  mac_opt_reg #(.W(OPW), .USE(A_PIPE0), .ASYNC(ASYNC_RST)) u_a0
    (.clk(clk), .en(en_a), .rst(rst_a), .d(op_a), .q(a0));
  mac_opt_reg #(.W(OPW), .USE(A_PIPE1), .ASYNC(ASYNC_RST)) u_a1
    (.clk(clk), .en(en_a), .rst(rst_a), .d(a0), .q(a1));
  mac_opt_reg #(.W(OPW), .USE(B_PIPE0), .ASYNC(ASYNC_RST)) u_b0
    (.clk(clk), .en(en_b), .rst(rst_b), .d(b_src), .q(b0));
  mac_opt_reg #(.W(OPW), .USE(D_PIPE), .ASYNC(ASYNC_RST)) u_d0
    (.clk(clk), .en(en_d), .rst(rst_d), .d(op_d), .q(d0));

  assign pre_out = f_pre(d0, b0, pre_sub);
  assign b_sel   = pre_en ? pre_out : b0;

  mac_opt_reg #(.W(OPW), .USE(B_PIPE1), .ASYNC(ASYNC_RST)) u_b1
    (.clk(clk), .en(en_b), .rst(rst_b), .d(b_sel), .q(b_mul));

  assign mul_raw = f_mul(a1, b_mul);

  mac_opt_reg #(.W(MULW), .USE(M_PIPE), .ASYNC(ASYNC_RST)) u_m
    (.clk(clk), .en(en_m), .rst(rst_m), .d(mul_raw), .q(mul_q));

  assign prod_ext = f_sext(mul_q);
  assign cat      = {d0[DCAT-1:0], a1, b_mul};
endmodule

// File: rtl/mac_back.sv
module mac_back
  import preadd_mac_pkg::*;
#(
  parameter bit C_PIPE  = 1'b1,
  parameter bit R_PIPE  = 1'b1,
  parameter bit CY_PIPE = 1'b1,
  parameter bit ASYNC_RST   = 1'b0,
  parameter bit CY_FROM_CTL = 1'b0
) (
  input  logic            clk,
  input  logic [CTLW-1:0] ctl_q,
  input  logic [ACCW-1:0] prod_ext,
  input  logic [ACCW-1:0] cat,
  input  logic [ACCW-1:0] op_c,
  input  logic [ACCW-1:0] casc_p_in,
  input  logic            cy_in,
  input  logic            en_c, en_r, en_cy,
  input  logic            rst_c, rst_r, rst_cy,
  output logic [ACCW-1:0] c_q,
  output logic            cin_q,
  output logic [ACCW:0]   sum_q
);
  logic            cin_src;
  logic [ACCW-1:0] x_op, z_op;
  logic [ACCW:0]   sum_d;

  mac_opt_reg #(.W(ACCW), .USE(C_PIPE), .ASYNC(ASYNC_RST)) u_c
    (.clk(clk), .en(en_c), .rst(rst_c), .d(op_c), .q(c_q));

  assign cin_src = CY_FROM_CTL ? ctl_q[5] : cy_in;

  mac_opt_reg #(.W(1), .USE(CY_PIPE), .ASYNC(ASYNC_RST)) u_cy
    (.clk(clk), .en(en_cy), .rst(rst_cy), .d(cin_src), .q(cin_q));

  assign x_op  = f_xsel(ctl_q[1:0], prod_ext, sum_q[ACCW-1:0], cat);
  assign z_op  = f_zsel(ctl_q[3:2], casc_p_in, sum_q[ACCW-1:0], c_q);
  assign sum_d = f_post(z_op, x_op, cin_q, ctl_q[7]);

  mac_opt_reg #(.W(ACCW+1), .USE(R_PIPE), .ASYNC(ASYNC_RST)) u_r
    (.clk(clk), .en(en_r), .rst(rst_r), .d(sum_d), .q(sum_q));
endmodule

// File: rtl/preadd_mac_slice.sv
module preadd_mac_slice
  import preadd_mac_pkg::*;
#(
  parameter bit A_PIPE0  = 1'b1,
  parameter bit A_PIPE1  = 1'b1,
  parameter bit B_PIPE0  = 1'b1,
  parameter bit B_PIPE1  = 1'b1,
  parameter bit C_PIPE   = 1'b1,
  parameter bit D_PIPE   = 1'b1,
  parameter bit M_PIPE   = 1'b1,
  parameter bit R_PIPE   = 1'b1,
  parameter bit CY_PIPE  = 1'b1,
  parameter bit CTL_PIPE = 1'b1,
  parameter bit ASYNC_RST   = 1'b0,
  parameter bit B_FROM_CASC = 1'b0,
  parameter bit CY_FROM_CTL = 1'b0
) (
  input  logic        clk,
  input  logic [17:0] op_a,
  input  logic [17:0] op_b,
  input  logic [17:0] casc_b_in,
  input  logic [17:0] op_d,
  input  logic [47:0] op_c,
  input  logic [47:0] casc_p_in,
  input  logic        cy_in,
  input  logic [7:0]  ctl,
  input  logic        en_a,
  input  logic        en_b,
  input  logic        en_c,
  input  logic        en_d,
  input  logic        en_m,
  input  logic        en_r,
  input  logic        en_cy,
  input  logic        en_ctl,
  input  logic        rst_a,
  input  logic        rst_b,
  input  logic        rst_c,
  input  logic        rst_d,
  input  logic        rst_m,
  input  logic        rst_r,
  input  logic        rst_cy,
  input  logic        rst_ctl,
  output logic [47:0] result,
  output logic [47:0] casc_p_out,
  output logic [17:0] casc_b_out,
  output logic        cy_out
);
  // Named internal wires, visible to the bound checker
  logic [CTLW-1:0] ctl_q;
  logic [ACCW-1:0] prod_ext, cat, c_q;
  logic            cin_q;
  logic [ACCW:0]   sum_q;

  mac_opt_reg #(.W(CTLW), .USE(CTL_PIPE), .ASYNC(ASYNC_RST)) u_ctl
    (.clk(clk), .en(en_ctl), .rst(rst_ctl), .d(ctl), .q(ctl_q));

  mac_front #(
    .A_PIPE0(A_PIPE0), .A_PIPE1(A_PIPE1), .B_PIPE0(B_PIPE0), .B_PIPE1(B_PIPE1),
    .D_PIPE(D_PIPE), .M_PIPE(M_PIPE), .ASYNC_RST(ASYNC_RST), .B_FROM_CASC(B_FROM_CASC)
  ) u_front (
    .clk(clk), .op_a(op_a), .op_b(op_b), .casc_b_in(casc_b_in), .op_d(op_d),
    .pre_en(ctl_q[4]), .pre_sub(ctl_q[6]),
    .en_a(en_a), .en_b(en_b), .en_d(en_d), .en_m(en_m),
    .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_m(rst_m),
    .prod_ext(prod_ext), .cat(cat), .b_mul(casc_b_out)
  );

  mac_back #(
    .C_PIPE(C_PIPE), .R_PIPE(R_PIPE), .CY_PIPE(CY_PIPE),
    .ASYNC_RST(ASYNC_RST), .CY_FROM_CTL(CY_FROM_CTL)
  ) u_back (
    .clk(clk), .ctl_q(ctl_q), .prod_ext(prod_ext), .cat(cat), .op_c(op_c),
    .casc_p_in(casc_p_in), .cy_in(cy_in),
    .en_c(en_c), .en_r(en_r), .en_cy(en_cy),
    .rst_c(rst_c), .rst_r(rst_r), .rst_cy(rst_cy),
    .c_q(c_q), .cin_q(cin_q), .sum_q(sum_q)
  );

  assign result     = sum_q[ACCW-1:0];
  assign casc_p_out = sum_q[ACCW-1:0];
  assign cy_out     = sum_q[ACCW];
endmodule

// File: rtl/preadd_mac_slice_chk.sv
module preadd_mac_slice_chk #(
  parameter bit R_PIPE  = 1'b1,
  parameter bit B_PIPE1 = 1'b1
) (
  input logic        clk,
  input logic        rst_r,
  input logic        en_r,
  input logic        rst_b,
  input logic        en_b,
  input logic [7:0]  ctl_q,
  input logic        cin_q,
  input logic [47:0] c_q,
  input logic [47:0] result,
  input logic        cy_out,
  input logic [17:0] casc_b_out
);
  generate
    if (R_PIPE) begin : g_r
      AST_RESULT_RESET: assert property (@(posedge clk)
        rst_r |=> (result == 48'd0 && !cy_out)); // R1
      AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst_r)
        !en_r |=> $stable(result)); // R8
      AST_XZ_ZERO: assert property (@(posedge clk) disable iff (rst_r)
        (en_r && ctl_q[3:0] == 4'b0000 && !cin_q) |=> (result == 48'd0)); // R3
      AST_Z_FROM_C: assert property (@(posedge clk) disable iff (rst_r)
        (en_r && ctl_q[3:0] == 4'b1100 && !ctl_q[7] && !cin_q) |=> (result == $past(c_q))); // R4
    end
    if (B_PIPE1) begin : g_b
      AST_BCASC_RESET: assert property (@(posedge clk)
        rst_b |=> (casc_b_out == 18'd0)); // R1
      AST_BCASC_HOLD: assert property (@(posedge clk) disable iff (rst_b)
        !en_b |=> $stable(casc_b_out)); // R8
    end
  endgenerate
endmodule

bind preadd_mac_slice preadd_mac_slice_chk #(.R_PIPE(R_PIPE), .B_PIPE1(B_PIPE1)) u_chk (
  .clk(clk), .rst_r(rst_r), .en_r(en_r), .rst_b(rst_b), .en_b(en_b),
  .ctl_q(ctl_q), .cin_q(cin_q), .c_q(c_q), .result(result), .cy_out(cy_out),
  .casc_b_out(casc_b_out)
);

// File: tb/preadd_mac_slice_tb.sv
module preadd_mac_slice_tb;
  logic        clk = 1'b0;
  logic [17:0] op_a = '0, op_b = '0, casc_b_in = '0, op_d = '0;
  logic [47:0] op_c = '0, casc_p_in = '0;
  logic        cy_in = 1'b0;
  logic [7:0]  ctl = '0;
  logic en_a = 1, en_b = 1, en_c = 1, en_d = 1, en_m = 1, en_r = 1, en_cy = 1, en_ctl = 1;
  logic rst_a = 1, rst_b = 1, rst_c = 1, rst_d = 1, rst_m = 1, rst_r = 1, rst_cy = 1, rst_ctl = 1;
  logic [47:0] result, casc_p_out;
  logic [17:0] casc_b_out;
  logic        cy_out;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  preadd_mac_slice u_dut (
    .clk(clk), .op_a(op_a), .op_b(op_b), .casc_b_in(casc_b_in), .op_d(op_d), .op_c(op_c),
    .casc_p_in(casc_p_in), .cy_in(cy_in), .ctl(ctl),
    .en_a(en_a), .en_b(en_b), .en_c(en_c), .en_d(en_d), .en_m(en_m), .en_r(en_r),
    .en_cy(en_cy), .en_ctl(en_ctl),
    .rst_a(rst_a), .rst_b(rst_b), .rst_c(rst_c), .rst_d(rst_d), .rst_m(rst_m), .rst_r(rst_r),
    .rst_cy(rst_cy), .rst_ctl(rst_ctl),
    .result(result), .casc_p_out(casc_p_out), .casc_b_out(casc_b_out), .cy_out(cy_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  ctl;
    logic [17:0] a, b, d;
    logic [47:0] c, pc;
    logic        cy;
    logic [47:0] exp;
    logic        ecy;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  8'h01, 18'd3,      18'd5, 18'd0,     48'd0,              48'd0,      1'b0, 48'd15,             1'b0}, // R3 product
    '{4'd11, 8'h01, 18'h3FFFE,  18'd7, 18'd0,     48'd0,              48'd0,      1'b0, 48'hFFFF_FFFF_FFF2, 1'b0}, // R11 sign extension
    '{4'd5,  8'h11, 18'd4,      18'd3, 18'd10,    48'd0,              48'd0,      1'b0, 48'd52,             1'b0}, // R5 D+B
    '{4'd5,  8'h51, 18'd4,      18'd3, 18'd10,    48'd0,              48'd0,      1'b0, 48'd28,             1'b0}, // R5 D-B
    '{4'd4,  8'h0C, 18'd0,      18'd0, 18'd0,     48'h1234_5678_9ABC, 48'd0,      1'b0, 48'h1234_5678_9ABC, 1'b0}, // R4 Z=C
    '{4'd6,  8'h8D, 18'd3,      18'd5, 18'd0,     48'd100,            48'd0,      1'b0, 48'd85,             1'b0}, // R6 subtract
    '{4'd7,  8'h0D, 18'd3,      18'd5, 18'd0,     48'd100,            48'd0,      1'b1, 48'd116,            1'b0}, // R7 external carry
    '{4'd6,  8'h8D, 18'd3,      18'd5, 18'd0,     48'd100,            48'd0,      1'b1, 48'd84,             1'b0}, // R6 subtract with carry
    '{4'd10, 8'h0F, 18'd0,      18'd1, 18'd0,     48'hFFFF_FFFF_FFFF, 48'd0,      1'b0, 48'd0,              1'b1}, // R10 carry out
    '{4'd3,  8'h03, 18'd1,      18'd2, 18'h00ABC, 48'd0,              48'd0,      1'b0, 48'hABC0_0004_0002, 1'b0}, // R3 concatenation
    '{4'd4,  8'h04, 18'd0,      18'd0, 18'd0,     48'd0,              48'hBEEF,   1'b0, 48'h0000_0000_BEEF, 1'b0}, // R4 Z=cascade
    '{4'd7,  8'h2D, 18'd3,      18'd5, 18'd0,     48'd100,            48'd0,      1'b0, 48'd115,            1'b0}, // R7 ctl[5] ignored
    '{4'd10, 8'h8D, 18'd1,      18'd1, 18'd0,     48'd0,              48'd0,      1'b0, 48'hFFFF_FFFF_FFFF, 1'b1}  // R10 borrow out
  };

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    edges(3);
    check("R1 result after reset", result, 48'd0);
    check("R1 cy_out after reset", {47'd0, cy_out}, 48'd0);
    check("R1 casc_b_out after reset", {30'd0, casc_b_out}, 48'd0);
    {rst_a, rst_b, rst_c, rst_d, rst_m, rst_r, rst_cy, rst_ctl} = '0;

    // Table of vectors, each held five edges
    for (int i = 0; i < NV; i++) begin
      ctl = VECS[i].ctl; op_a = VECS[i].a; op_b = VECS[i].b; op_d = VECS[i].d;
      op_c = VECS[i].c; casc_p_in = VECS[i].pc; cy_in = VECS[i].cy;
      edges(5);
      check($sformatf("R%0d vector %0d result", VECS[i].req, i), result, VECS[i].exp);
      check($sformatf("R%0d vector %0d cy_out", VECS[i].req, i), {47'd0, cy_out}, {47'd0, VECS[i].ecy});
      check($sformatf("R10 vector %0d cascade", i), casc_p_out, result);
    end

    // R2: four-edge latency
    ctl = 8'h01; op_a = 18'd3; op_b = 18'd5; op_d = '0; op_c = '0; casc_p_in = '0; cy_in = 1'b0;
    edges(5);
    op_a = 18'd6;
    edges(3);
    check("R2 result before 4th edge", result, 48'd15);
    edges(1);
    check("R2 result at 4th edge", result, 48'd30);

    // R8: enable low holds result
    en_r = 1'b0; op_a = 18'd7;
    edges(5);
    check("R8 result held", result, 48'd30);
    en_r = 1'b1;
    edges(1);
    check("R8 result after re-enable", result, 48'd35);

    // R9: B cascade output
    op_b = 18'd9;
    edges(3);
    check("R9 casc_b_out direct", {30'd0, casc_b_out}, 48'd9);
    ctl = 8'h11; op_d = 18'd1;
    edges(3);
    check("R9 casc_b_out pre-added", {30'd0, casc_b_out}, 48'd10);

    // R12: accumulation, result feedback as Z
    ctl = 8'h09; op_a = 18'd3; op_b = 18'd5; op_d = '0; rst_r = 1'b1;
    edges(4);
    check("R1 result held in reset", result, 48'd0);
    rst_r = 1'b0;
    edges(3);
    check("R12 accumulated three products", result, 48'd45);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule